// File: doc/BRIEF.md
# DMA Completion Interrupt Aggregator

This block collects transfer-completion reports from a DMA engine and turns them into interrupt requests for the CPU. A report arrives with a valid strobe and carries a 6-bit completion code, a flag that tells a final completion from an intermediate one, and the two per-transfer interrupt enable flags taken from that transfer's options. The completion code, not the channel number, picks the bit of a 32-bit pending register that the report sets. Any number of channels may therefore share one pending bit and one service routine. The report carries nothing that tells an early completion from a normal one, because both set the bit in the same way.

The pending bits are gated by an interrupt-enable register and by one 32-bit mask per region. Each region's request is then reduced to one registered, level-sensitive interrupt line. Software reaches the state through a small word-wide register port. It can read the pending, enable and mask registers. It clears pending bits by writing ones, and it sets or clears enable bits by writing ones to two separate addresses.

Top module: `dma_cmpl_irq`

## Requirements
- R1: A valid report whose code n is in 0..31, and whose matching enable flag is 1, sets pending bit n at the next clock edge and no other bit.
- R2: A report with rpt_final=1 sets its bit only when rpt_fin_en=1, and a report with rpt_final=0 sets its bit only when rpt_mid_en=1. The flag that does not match the completion kind has no effect.
- R3: A report with a code in 32..63 sets no pending bit.
- R4: Pending bits are sticky until cleared. Repeated reports with the same code keep a single bit set, and reports with different codes accumulate.
- R5: Writing to address 1 clears every pending bit whose data bit is 1. When a report sets a bit in the same cycle that the write clears it, the bit ends up set.
- R6: Writing to address 3 sets the enable bits whose data bit is 1, and writing to address 4 clears them. Bits written as 0 keep their value.
- R7: Region r's interrupt output becomes, one clock after the registers settle, the OR over all bits of pending AND enable AND region r's mask.
- R8: Region r's mask is written and read at address 8+r, and a write to one region's mask leaves the other region unchanged.
- R9: After reset, pending, enable and all masks are zero and every interrupt output is low.
- R10: reg_rdata is registered and returns, one clock after an address is presented, the register at that address: 0 pending, 2 enable, 8+r mask r. Every other address reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rpt_valid | input | 1 | A completion report is present this cycle |
| rpt_code | input | 6 | Completion code of the report |
| rpt_final | input | 1 | 1 = final completion, 0 = intermediate completion |
| rpt_fin_en | input | 1 | Transfer's interrupt enable for final completion |
| rpt_mid_en | input | 1 | Transfer's interrupt enable for intermediate completion |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| irq_out | output | 2 | One level interrupt per region |

## Verification
The hardest case to reach is a report and a software clear that hit the same pending bit in the same cycle. The ordinary write and report helper tasks never overlap. The race test therefore drives the report strobe and a clear write of the pending register on the same falling edge. The clear covers both the bit being reported and a bit that is already pending, so one write shows both the set winning and the plain clear working. The interrupt outputs are checked both before and after their register stage, which shows the one-cycle delay.

// File: rtl/dci_pkg.sv
package dci_pkg;
  localparam int DCI_AW = 4;

  typedef enum logic [DCI_AW-1:0] {
    ADR_PEND     = 4'd0,
    ADR_PEND_CLR = 4'd1,
    ADR_ENA      = 4'd2,
    ADR_ENA_SET  = 4'd3,
    ADR_ENA_CLR  = 4'd4
  } dci_addr_e;

  localparam logic [DCI_AW-1:0] ADR_MASK_BASE = 4'd8;
endpackage

// File: rtl/dci_decode.sv
module dci_decode #(
  parameter int CODE_W = 6,
  parameter int NB     = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  logic [CODE_W-1:0] code,
  input  logic              is_final,
  input  logic              fin_en,
  input  logic              mid_en,
  output logic [NB-1:0]     set_vec
);
  logic gate_ok;

  always_comb gate_ok = valid && (is_final ? fin_en : mid_en);

  for (genvar i = 0; i < NB; i++) begin : g_bit
    always_comb set_vec[i] = gate_ok && (code == CODE_W'(i));
  end

  assert_onehot_set_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(set_vec));

  assert_gate_R2: assert property (@(posedge clk) disable iff (rst)
    (valid && is_final && !fin_en) |-> (set_vec == '0));
endmodule

// File: rtl/dci_pending.sv
module dci_pending #(
  parameter int NB = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NB-1:0] set_vec,
  input  logic [NB-1:0] clr_vec,
  output logic [NB-1:0] pend
);
  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= (pend & ~clr_vec) | set_vec;
  end

  assert_set_wins_R5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend & $past(set_vec)) == $past(set_vec)));

  assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend & $past(clr_vec & ~set_vec)) == '0));

  assert_no_spurious_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend & ~$past(pend) & ~$past(set_vec)) == '0));
endmodule

// File: rtl/dci_enable.sv
module dci_enable #(
  parameter int NB = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NB-1:0] set_w,
  input  logic [NB-1:0] clr_w,
  output logic [NB-1:0] en
);
  always_ff @(posedge clk) begin
    if (rst) en <= '0;
    else     en <= (en | set_w) & ~clr_w;
  end

  assert_en_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (set_w == '0 && clr_w == '0) |=> $stable(en));
endmodule

// File: rtl/dci_regions.sv
module dci_regions #(
  parameter int NB = 32,
  parameter int NR = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NR-1:0] mask_wr,
  input  logic [NB-1:0] wdata,
  input  logic [NB-1:0] active,
  output logic [NB-1:0] mask [NR],
  output logic [NR-1:0] irq
);
  for (genvar r = 0; r < NR; r++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        mask[r] <= '0;
        irq[r]  <= 1'b0;
      end else begin
        if (mask_wr[r]) mask[r] <= wdata;
        irq[r] <= |(active & mask[r]);
      end
    end

    assert_mask_hold_R8: assert property (@(posedge clk) disable iff (rst)
      !mask_wr[r] |=> $stable(mask[r]));
  end
endmodule

// File: rtl/dma_cmpl_irq.sv
module dma_cmpl_irq #(
  parameter int CODE_W  = 6,
  parameter int NB      = 32,
  parameter int NR      = 2,
  parameter int ADDR_W  = dci_pkg::DCI_AW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rpt_valid,
  input  logic [CODE_W-1:0] rpt_code,
  input  logic              rpt_final,
  input  logic              rpt_fin_en,
  input  logic              rpt_mid_en,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [NB-1:0]     reg_wdata,
  output logic [NB-1:0]     reg_rdata,
  output logic [NR-1:0]     irq_out
);
  import dci_pkg::*;

  logic [NB-1:0] set_vec, clr_vec, ena_set, ena_clr;
  logic [NB-1:0] pend, en, active;
  logic [NB-1:0] mask [NR];
  logic [NR-1:0] mask_wr;
  logic [NB-1:0] rd_next;

  always_comb begin
    clr_vec = (reg_wr && reg_addr == ADR_PEND_CLR) ? reg_wdata : '0;
    ena_set = (reg_wr && reg_addr == ADR_ENA_SET)  ? reg_wdata : '0;
    ena_clr = (reg_wr && reg_addr == ADR_ENA_CLR)  ? reg_wdata : '0;
  end

  for (genvar r = 0; r < NR; r++) begin : g_mwr
    always_comb mask_wr[r] = reg_wr && (reg_addr == ADR_MASK_BASE + ADDR_W'(r));
  end

  dci_decode #(.CODE_W(CODE_W), .NB(NB)) u_decode (
    .clk(clk), .rst(rst), .valid(rpt_valid), .code(rpt_code),
    .is_final(rpt_final), .fin_en(rpt_fin_en), .mid_en(rpt_mid_en),
    .set_vec(set_vec)
  );

  dci_pending #(.NB(NB)) u_pending (
    .clk(clk), .rst(rst), .set_vec(set_vec), .clr_vec(clr_vec), .pend(pend)
  );

  dci_enable #(.NB(NB)) u_enable (
    .clk(clk), .rst(rst), .set_w(ena_set), .clr_w(ena_clr), .en(en)
  );

  always_comb active = pend & en;

  dci_regions #(.NB(NB), .NR(NR)) u_regions (
    .clk(clk), .rst(rst), .mask_wr(mask_wr), .wdata(reg_wdata),
    .active(active), .mask(mask), .irq(irq_out)
  );

  always_comb begin
    rd_next = '0;
    if (reg_addr == ADR_PEND) rd_next = pend;
    if (reg_addr == ADR_ENA)  rd_next = en;
    for (int r = 0; r < NR; r++)
      if (reg_addr == ADR_MASK_BASE + ADDR_W'(r)) rd_next = mask[r];
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_next;
  end

  assert_irq_gate_R7: assert property (@(posedge clk) disable iff (rst)
    ((pend & en) == '0) |=> (irq_out == '0));

  assert_reset_quiet_R9: assert property (@(posedge clk)
    $past(rst) |-> (irq_out == '0 && pend == '0));
endmodule

// File: tb/test_dma_cmpl_irq.sv
module test_dma_cmpl_irq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rpt_valid = 1'b0;
  logic [5:0]  rpt_code = '0;
  logic        rpt_final = 1'b0, rpt_fin_en = 1'b0, rpt_mid_en = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [1:0]  irq_out;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_cmpl_irq i_dma_cmpl_irq (
    .clk(clk), .rst(rst), .rpt_valid(rpt_valid), .rpt_code(rpt_code),
    .rpt_final(rpt_final), .rpt_fin_en(rpt_fin_en), .rpt_mid_en(rpt_mid_en),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report(logic [5:0] code, logic fin, logic fen, logic men);
    @(negedge clk);
    rpt_valid = 1'b1; rpt_code = code; rpt_final = fin;
    rpt_fin_en = fen; rpt_mid_en = men;
    @(negedge clk);
    rpt_valid = 1'b0;
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R9 irq", {30'd0, irq_out}, 32'd0);
    rd(4'd0, v); chk("R9 pend", v, 32'd0);
    rd(4'd2, v); chk("R9 enable", v, 32'd0);
    rd(4'd8, v); chk("R9 mask0", v, 32'd0);
  endtask

  task automatic t_decode;
    logic [31:0] v;
    int codes [4] = '{0, 1, 17, 31};
    foreach (codes[k]) begin
      report(6'(codes[k]), 1'b1, 1'b1, 1'b0);
      rd(4'd0, v); chk("R1 decode", v, 32'd1 << codes[k]);
      wr(4'd1, 32'hFFFF_FFFF);
    end
  endtask

  task automatic t_gating;
    logic [31:0] v;
    report(6'd2, 1'b1, 1'b0, 1'b1);
    rd(4'd0, v); chk("R2 final blocked", v, 32'd0);
    report(6'd2, 1'b1, 1'b1, 1'b0);
    rd(4'd0, v); chk("R2 final allowed", v, 32'd4);
    wr(4'd1, 32'hFFFF_FFFF);
    report(6'd7, 1'b0, 1'b1, 1'b0);
    rd(4'd0, v); chk("R2 mid blocked", v, 32'd0);
    report(6'd7, 1'b0, 1'b0, 1'b1);
    rd(4'd0, v); chk("R2 mid allowed", v, 32'h80);
    wr(4'd1, 32'hFFFF_FFFF);
  endtask

  task automatic t_range;
    logic [31:0] v;
    report(6'd32, 1'b1, 1'b1, 1'b1);
    report(6'd45, 1'b0, 1'b1, 1'b1);
    report(6'd63, 1'b1, 1'b1, 1'b1);
    rd(4'd0, v); chk("R3 high codes", v, 32'd0);
  endtask

  task automatic t_shared;
    logic [31:0] v;
    report(6'd9, 1'b1, 1'b1, 1'b0);
    report(6'd9, 1'b0, 1'b0, 1'b1);
    rd(4'd0, v); chk("R4 shared code", v, 32'h200);
    report(6'd3, 1'b1, 1'b1, 1'b0);
    rd(4'd0, v); chk("R4 accumulate", v, 32'h208);
    wr(4'd1, 32'h0000_0200);
    rd(4'd0, v); chk("R5 partial clear", v, 32'h8);
    wr(4'd1, 32'hFFFF_FFFF);
  endtask

  task automatic t_race;
    logic [31:0] v;
    report(6'd6, 1'b1, 1'b1, 1'b0);
    @(negedge clk);
    rpt_valid = 1'b1; rpt_code = 6'd5; rpt_final = 1'b1;
    rpt_fin_en = 1'b1; rpt_mid_en = 1'b0;
    reg_wr = 1'b1; reg_addr = 4'd1; reg_wdata = 32'h60;
    @(negedge clk);
    rpt_valid = 1'b0; reg_wr = 1'b0;
    rd(4'd0, v); chk("R5 set wins", v, 32'h20);
    wr(4'd1, 32'hFFFF_FFFF);
  endtask

  task automatic t_enable;
    logic [31:0] v;
    wr(4'd3, 32'h0000_00F0);
    wr(4'd3, 32'h0000_000F);
    rd(4'd2, v); chk("R6 set", v, 32'hFF);
    wr(4'd4, 32'h0000_003C);
    rd(4'd2, v); chk("R6 clear", v, 32'hC3);
    wr(4'd4, 32'hFFFF_FFFF);
  endtask

  task automatic t_irq;
    wr(4'd8, 32'h0000_0010);
    wr(4'd9, 32'h0000_0100);
    wr(4'd3, 32'h0000_0110);
    report(6'd4, 1'b1, 1'b1, 1'b0);
    chk("R7 latency", {30'd0, irq_out}, 32'd0);
    @(negedge clk);
    chk("R7 region0", {30'd0, irq_out}, 32'd1);
    report(6'd8, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    chk("R7 both", {30'd0, irq_out}, 32'd3);
    wr(4'd4, 32'h0000_0010);
    @(negedge clk);
    chk("R7 enable gates", {30'd0, irq_out}, 32'd2);
    wr(4'd9, 32'h0);
    @(negedge clk);
    chk("R7 mask gates", {30'd0, irq_out}, 32'd0);
    wr(4'd1, 32'hFFFF_FFFF);
    wr(4'd4, 32'hFFFF_FFFF);
  endtask

  task automatic t_mask;
    logic [31:0] v;
    wr(4'd9, 32'hA5A5_0F0F);
    rd(4'd9, v); chk("R8 mask1", v, 32'hA5A5_0F0F);
    rd(4'd8, v); chk("R8 mask0 kept", v, 32'h10);
    rd(4'd5, v); chk("R10 unmapped", v, 32'd0);
    rd(4'd15, v); chk("R10 unmapped top", v, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_decode;
    t_gating;
    t_range;
    t_shared;
    t_race;
    t_enable;
    t_irq;
    t_mask;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule